// File: doc/BRIEF.md
# Timer Tick Source and Control Register

This block holds the 8-bit control word of a general-purpose timer channel and produces that timer's count. A three-bit field in the word chooses the count tick. Seven of its codes take a divided version of the system clock from one free-running prescaler. The eighth code takes edges of an external clock pin, which is brought into the system clock domain first. An 8-bit up-counter advances once per tick. When it wraps from 0xFF to 0x00, it sets an interrupt flag.

Software reaches the block through a simple write-enable, write-data and read-data port. The same word holds the interrupt flag, an active-low reload control, the idle level of the timer output, and the choice of external clock edge. It also holds a self-clearing strobe that copies the live count into a readable capture register. The flag clears when software writes 0 to it or when the interrupt controller sends an acknowledge pulse. Writing 1 to the flag leaves it unchanged. If an overflow event falls in the same cycle as a clear, the event wins.

Top module: `tmr_ctl_top`

## Requirements
- R1: After synchronous reset the control word reads 0x00. Bits [7:5] are the tick select, bit 4 the interrupt flag, bit 3 the reload control, bit 2 the idle polarity, bit 1 the external edge select and bit 0 the capture strobe. A read returns bits 7..1 as stored and bit 0 always as 0.
- R2: Tick select codes 0..6 give one tick every 2048, 512, 64, 8, 4, 2 and 1 system clocks. A tick is issued in the cycle where the low log2(ratio) bits of an 11-bit free-running counter are all ones. That counter resets to 0 and increments every cycle.
- R3: Tick select code 7 counts external pin edges: falling edges when bit 1 is 0, rising edges when bit 1 is 1. The pin passes two synchronizer flops and one edge-history flop, so the count changes on the third rising system-clock edge after the pin changes.
- R4: Output `reload_en` is the inverse of control bit 3: 0 enables reload and 1 disables it. It follows each write on the next clock edge.
- R5: The interrupt flag is set on the clock edge where the counter wraps from 0xFF to 0x00. It is cleared by a write with bit 4 = 0 or by a one-cycle `int_ack`. A write with bit 4 = 1 does not change it.
- R6: Output `idle_lvl` equals control bit 2: low for polarity 0 and high for polarity 1.
- R7: A write with bit 0 = 1 makes `cap_data` load, on the next clock edge, the counter value present after the write edge. A write with bit 0 = 0 leaves `cap_data` unchanged.
- R8: An overflow event in the same cycle as a flag clear, whether from a write of 0 or from `int_ack`, leaves the flag at 1.
- R9: The counter is 8 bits wide, resets to 0 and advances by exactly one on each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word readback |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| cnt_val | output | 8 | Live counter value |
| cap_data | output | 8 | Capture (B data) register |
| idle_lvl | output | 1 | Timer output level while disabled |
| reload_en | output | 1 | Active-high reload enable |

## Verification
Control fields, `idle_lvl` and `reload_en` are due one edge after a write. The flag responds on the same edge as the wrap or the clear. `cap_data` is due two edges after a capture write, and an external pin change reaches the count on the third edge. The bench updates a behavioural model at every rising edge, using the same pre-edge inputs, and compares all outputs at the following falling edge. Directed checks are timed by hand to these delays.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 11;
  localparam int SEL_W  = 3;
  localparam int N_DIV  = 7;
  localparam logic [SEL_W-1:0] SEL_EXT = 3'd7;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             flag;
    logic             rld_n;
    logic             pol;
    logic             edg;
  } ctl_t;

  function automatic int div_log(input int code);
    case (code)
      0: div_log = 11;
      1: div_log = 9;
      2: div_log = 6;
      3: div_log = 3;
      4: div_log = 2;
      5: div_log = 1;
      default: div_log = 0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler import tmr_pkg::*; #(
  parameter int PW = PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PW-1:0]    pre_q;
  logic [N_DIV-1:0] tick_v;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    localparam int LG = div_log(g);
    localparam logic [PW-1:0] MASK = PW'((1 << LG) - 1);
    assign tick_v[g] = ((pre_q & MASK) == MASK);
  end

  always_comb begin
    tick = 1'b0;
    if (sel != SEL_EXT) tick = tick_v[sel];
  end
endmodule

// File: rtl/tmr_extedge.sv
module tmr_extedge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic tick
);
  logic [SYNC_N-1:0] sync_q;
  logic              hist_q;
  logic              cur;

  assign cur = sync_q[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin};
      hist_q <= cur;
    end
  end

  assign tick = rise_sel ? (cur & ~hist_q) : (~cur & hist_q);
endmodule

// File: rtl/tmr_ctlreg.sv
module tmr_ctlreg import tmr_pkg::*; #(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          int_ack,
  input  logic          ovf_evt,
  input  logic [CW-1:0] cnt,
  output ctl_t          ctl,
  output logic [CW-1:0] cap
);
  logic cap_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      cap_pend <= 1'b0;
      cap      <= '0;
    end else begin
      if (wr_en) begin
        ctl.sel   <= wr_data[7:5];
        ctl.rld_n <= wr_data[3];
        ctl.pol   <= wr_data[2];
        ctl.edg   <= wr_data[1];
      end
      if (ovf_evt)                      ctl.flag <= 1'b1;
      else if (wr_en && !wr_data[4])    ctl.flag <= 1'b0;
      else if (int_ack)                 ctl.flag <= 1'b0;
      if (cap_pend) cap <= cnt;
      cap_pend <= wr_en && wr_data[0];
    end
  end
endmodule

// File: rtl/tmr_ctl_top.sv
module tmr_ctl_top import tmr_pkg::*; #(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    ctl_rdata,
  input  logic          ext_clk,
  input  logic          int_ack,
  output logic [CW-1:0] cnt_val,
  output logic [CW-1:0] cap_data,
  output logic          idle_lvl,
  output logic          reload_en
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  ctl_t          ctl;
  logic          pre_tick, ext_tick, tick, ovf_evt;
  logic [CW-1:0] cnt_q;

  tmr_prescaler #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst), .sel(ctl.sel), .tick(pre_tick)
  );

  tmr_extedge #(.SYNC_N(2)) u_ext (
    .clk(clk), .rst(rst), .pin(ext_clk), .rise_sel(ctl.edg), .tick(ext_tick)
  );

  assign tick    = (ctl.sel == SEL_EXT) ? ext_tick : pre_tick;
  assign ovf_evt = tick && (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  tmr_ctlreg #(.CW(CW)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .int_ack(int_ack), .ovf_evt(ovf_evt), .cnt(cnt_q),
    .ctl(ctl), .cap(cap_data)
  );

  assign cnt_val   = cnt_q;
  assign ctl_rdata = {ctl.sel, ctl.flag, ctl.rld_n, ctl.pol, ctl.edg, 1'b0};
  assign idle_lvl  = ctl.pol;
  assign reload_en = ~ctl.rld_n;
endmodule

// File: rtl/tmr_ctl_chk.sv
module tmr_ctl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic [7:0]    ctl_rdata,
  input logic          int_ack,
  input logic [CW-1:0] cnt_val,
  input logic [CW-1:0] cap_data,
  input logic          idle_lvl,
  input logic          reload_en
);
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_val) == {CW{1'b1}} && cnt_val == '0) |-> ctl_rdata[4]); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (int_ack && cnt_val != {CW{1'b1}}) |=> !ctl_rdata[4]); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_val == $past(cnt_val)) || (cnt_val == CW'($past(cnt_val) + 1'b1))); // R9
  AST_RELOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (reload_en == !$past(wr_data[3]))); // R4
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (idle_lvl == $past(wr_data[2]))); // R6
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[0]) |=> ##1 (cap_data == $past(cnt_val))); // R7
endmodule

bind tmr_ctl_top tmr_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .ctl_rdata(ctl_rdata), .int_ack(int_ack), .cnt_val(cnt_val),
  .cap_data(cap_data), .idle_lvl(idle_lvl), .reload_en(reload_en)
);

// File: tb/tmr_ctl_top_test.sv
module tmr_ctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ext_clk = 1'b0;
  logic       int_ack = 1'b0;
  logic [7:0] ctl_rdata, cnt_val, cap_data;
  logic       idle_lvl, reload_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit model_live = 0;

  // reference model state
  int m_pre, m_cnt, m_sel, m_cap;
  bit m_s1, m_s2, m_s3, m_flag, m_rld, m_pol, m_edg, m_pend;

  tmr_ctl_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_rdata(ctl_rdata), .ext_clk(ext_clk), .int_ack(int_ack),
    .cnt_val(cnt_val), .cap_data(cap_data), .idle_lvl(idle_lvl),
    .reload_en(reload_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int ratio_of(input int s);
    int r [7] = '{2048, 512, 64, 8, 4, 2, 1};
    return r[s];
  endfunction

  always @(posedge clk) begin
    bit tk, ev;
    cyc++;
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_sel = 0; m_cap = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_flag = 0;
      m_rld = 0; m_pol = 0; m_edg = 0; m_pend = 0;
      model_live = 1;
    end else begin
      if (m_sel == 7) tk = m_edg ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
      else            tk = ((m_pre % ratio_of(m_sel)) == ratio_of(m_sel) - 1);
      ev = tk && (m_cnt == 255);
      if (m_pend) m_cap = m_cnt;
      m_pend = wr_en && wr_data[0];
      if (ev) m_flag = 1;
      else if (wr_en && !wr_data[4]) m_flag = 0;
      else if (int_ack) m_flag = 0;
      if (wr_en) begin
        m_sel = wr_data[7:5]; m_rld = wr_data[3];
        m_pol = wr_data[2];   m_edg = wr_data[1];
      end
      if (tk) m_cnt = (m_cnt + 1) % 256;
      m_pre = (m_pre + 1) % 2048;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    end
  end

  always @(negedge clk) begin
    if (model_live && !done) begin
      int exp_rd;
      exp_rd = (m_sel << 5) | (m_flag << 4) | (m_rld << 3) | (m_pol << 2) | (m_edg << 1);
      chk(ctl_rdata[7:5] == m_sel[2:0], "R1 select field", ctl_rdata, exp_rd);
      chk(ctl_rdata[4] == m_flag, "R5 flag", ctl_rdata, exp_rd);
      chk({ctl_rdata[3:1], ctl_rdata[0]} == {m_rld, m_pol, m_edg, 1'b0}, "R1 low fields", ctl_rdata, exp_rd);
      chk(cnt_val == m_cnt[7:0], m_sel == 7 ? "R3 ext count" : "R2 R9 count", cnt_val, m_cnt);
      chk(cap_data == m_cap[7:0], "R7 capture", cap_data, m_cap);
      chk(idle_lvl == m_pol, "R6 idle level", idle_lvl, m_pol);
      chk(reload_en == !m_rld, "R4 reload", reload_en, !m_rld);
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG_LIMIT && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WDOG_LIMIT);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_rdata == 8'h00, "R1 reset word", ctl_rdata, 0);
    chk(reload_en == 1'b1, "R4 reset reload", reload_en, 1);

    // divide-by-1: 256 ticks reach a wrap
    wr(8'hC0);
    idle(300);
    chk(ctl_rdata[4] == 1'b1, "R5 flag after wrap", ctl_rdata[4], 1);
    wr(8'hD0);
    chk(ctl_rdata[4] == 1'b1, "R5 write 1 keeps flag", ctl_rdata[4], 1);
    wr(8'hC0);
    chk(ctl_rdata[4] == 1'b0, "R5 write 0 clears", ctl_rdata[4], 0);
    idle(270);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    chk(ctl_rdata[4] == 1'b0, "R5 ack clears", ctl_rdata[4], 0);

    // event wins over a clear in the same cycle
    while (cnt_val != 8'hFF) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hC0; int_ack = 1'b1;
    @(negedge clk); wr_en = 1'b0; int_ack = 1'b0;
    chk(ctl_rdata[4] == 1'b1, "R8 event beats clear", ctl_rdata[4], 1);
    chk(cnt_val == 8'h00, "R9 wrap to zero", cnt_val, 0);

    // capture
    idle(5);
    wr(8'hC1);
    @(negedge clk);
    chk(ctl_rdata[0] == 1'b0, "R1 strobe reads 0", ctl_rdata[0], 0);

    // polarity and reload fields
    wr(8'hCC);
    chk(idle_lvl == 1'b1 && reload_en == 1'b0, "R6 R4 set", {idle_lvl, reload_en}, 2'b10);

    // each divider ratio
    for (int s = 0; s < 7; s++) begin
      wr(8'(s << 5) | 8'h01);
      idle(s == 0 ? 5000 : 700);
    end

    // external clock, falling then rising
    wr(8'hE0);
    for (int k = 0; k < 40; k++) begin ext_clk = ~ext_clk; idle(4); end
    wr(8'hE2);
    for (int k = 0; k < 40; k++) begin ext_clk = ~ext_clk; idle(3); end
    wr(8'hE3);
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule